// File: doc/BRIEF.md
# Three-Input Ternary Bitwise Logic Unit

This unit evaluates an arbitrary Boolean function of three wide vector operands, bit by bit. An 8-bit immediate is a truth table. For every bit position, the three operand bits at that position form a 3-bit index, and the output bit is the immediate bit at that index. One immediate can therefore express any of the 256 three-input functions, including three-way XOR, majority and bitwise select.

After the lookup, a per-element predicate can be applied. The operands are viewed as 32-bit or 64-bit elements, and one mask bit governs each element. A masked-off element is either cleared or filled with the matching bits of the first operand. The element size changes only the mask granularity. It never changes the unmasked bits.

An accepted operation produces its result in an output register one clock after it is presented. While no operation is presented, the register holds its value.

Top module: `ternlog_unit`

## Requirements
- R1: With `mask_on` low, every bit i of `res` equals `tt_imm[{opa[i], opb[i], opc[i]}]`, where `opa` is the most significant index bit and `opc` is the least significant.
- R2: With `mask_on` low, `elem_wide` has no effect on `res`.
- R3: With `elem_wide` = 0 (32-bit elements), mask bit k governs result bits 32k+31 down to 32k.
- R4: With `elem_wide` = 1 (64-bit elements), mask bit j governs result bits 64j+63 down to 64j, and mask bits 15 to 8 have no effect.
- R5: When `mask_on` = 1 and `zero_fill` = 1, every bit of a masked-off element (its mask bit is 0) is 0.
- R6: When `mask_on` = 1 and `zero_fill` = 0, every bit of a masked-off element equals the same bit of `opa`.
- R7: `res_vld` is high exactly in the cycle after `op_vld` was high, and `res` then carries that operation's result.
- R8: While `op_vld` is low, `res` keeps its value whatever the other inputs do.
- R9: After reset, `res_vld` is 0 and `res` is all zeros.
- R10: With mask off, immediate 0x96 gives opa^opb^opc, immediate 0xE8 gives the bitwise majority, and immediate 0xCA gives opa ? opb : opc per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_vld | input | 1 | Operation presented this cycle |
| opa | input | 512 | First operand; MSB of the lookup index; merge fill source |
| opb | input | 512 | Second operand; middle index bit |
| opc | input | 512 | Third operand; LSB of the lookup index |
| tt_imm | input | 8 | Truth table of the function |
| elem_wide | input | 1 | 0: 32-bit elements, 1: 64-bit elements |
| elem_mask | input | 16 | One bit per element, with the low bits used first |
| mask_on | input | 1 | Enables predication |
| zero_fill | input | 1 | 1: clear masked-off elements, 0: keep opa |
| res_vld | output | 1 | Result valid |
| res | output | 512 | Registered result |

## Verification
The hardest cases to reach are the cases where the mask width and the element size disagree. These are mask bits 15 to 8 under 64-bit elements, and the two 32-bit halves of a 64-bit element that end up under different mask bits. Random operands and immediates alone rarely isolate these cases. Directed cases therefore set only the upper mask bits in 64-bit mode, and set alternating single-bit masks in 32-bit mode. The same operands are then run in both fill modes, so that any leak between neighbouring elements shows in the result. Random stimulus with random immediates, masks and modes covers the rest against a bench reference function.

// File: rtl/ternlog_pkg.sv
package ternlog_pkg;

    localparam int unsigned DEF_VEC_W  = 512;
    localparam int unsigned ELEM_LO_W  = 32;
    localparam int unsigned ELEM_HI_W  = 64;
    localparam int unsigned TT_W       = 8;

    typedef enum logic {
        ESZ_DWORD = 1'b0,
        ESZ_QWORD = 1'b1
    } elem_sel_e;

    typedef enum logic {
        FILL_KEEP_A = 1'b0,
        FILL_ZERO   = 1'b1
    } fill_sel_e;

endpackage

// File: rtl/ternlog_truth_slice.sv
module ternlog_truth_slice #(
    parameter int unsigned VEC_W = 512,
    parameter int unsigned TT_W  = 8
) (
    input  logic [VEC_W-1:0] in_a,
    input  logic [VEC_W-1:0] in_b,
    input  logic [VEC_W-1:0] in_c,
    input  logic [TT_W-1:0]  table_bits,
    output logic [VEC_W-1:0] lut_out
);

    // Each bit position is an independent 8:1 selection of the table.
    for (genvar i = 0; i < VEC_W; i++) begin : g_bit
        logic [2:0] sel;
        assign sel        = {in_a[i], in_b[i], in_c[i]};
        assign lut_out[i] = table_bits[sel];
    end

endmodule

// File: rtl/ternlog_lane_pred.sv
module ternlog_lane_pred
    import ternlog_pkg::*;
#(
    parameter int unsigned VEC_W = 512,
    localparam int unsigned LANES_LO = VEC_W / ELEM_LO_W,
    localparam int unsigned LANES_HI = VEC_W / ELEM_HI_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  elem_sel_e           esz,
    input  logic [LANES_LO-1:0] mask,
    input  logic                mask_en,
    output logic [VEC_W-1:0]    bit_en
);

    for (genvar g = 0; g < LANES_HI; g++) begin : g_pair
        logic en_lo;
        logic en_hi;
        always_comb begin
            if (!mask_en) begin
                en_lo = 1'b1;
                en_hi = 1'b1;
            end else if (esz == ESZ_QWORD) begin
                en_lo = mask[g];
                en_hi = mask[g];
            end else begin
                en_lo = mask[2*g];
                en_hi = mask[2*g+1];
            end
        end
        assign bit_en[(2*g)*ELEM_LO_W   +: ELEM_LO_W] = {ELEM_LO_W{en_lo}};
        assign bit_en[(2*g+1)*ELEM_LO_W +: ELEM_LO_W] = {ELEM_LO_W{en_hi}};

        // R4: both halves of a wide element share one predicate
        a_r4_pair_shared: assert property (@(posedge clk) disable iff (!rst_n)
            (esz == ESZ_QWORD) |->
            (bit_en[(2*g+1)*ELEM_LO_W +: ELEM_LO_W] == bit_en[(2*g)*ELEM_LO_W +: ELEM_LO_W]));
    end

    // R1: no predication leaves every bit enabled
    a_r1_all_enabled: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_en |-> (&bit_en));

endmodule

// File: rtl/ternlog_out_stage.sv
module ternlog_out_stage
    import ternlog_pkg::*;
#(
    parameter int unsigned VEC_W = 512
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take,
    input  logic [VEC_W-1:0] lut_val,
    input  logic [VEC_W-1:0] keep_val,
    input  logic [VEC_W-1:0] bit_en,
    input  fill_sel_e        fill,
    output logic             vld_q,
    output logic [VEC_W-1:0] res_q
);

    logic [VEC_W-1:0] fill_val;
    logic [VEC_W-1:0] res_d;

    assign fill_val = (fill == FILL_ZERO) ? '0 : keep_val;
    assign res_d    = (lut_val & bit_en) | (fill_val & ~bit_en);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= take;
            if (take) begin
                res_q <= res_d;
            end
        end
    end

    a_r7_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> vld_q);
    a_r7_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> !vld_q);
    a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !take |=> $stable(res_q));
    a_r5_zero_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fill == FILL_ZERO) |=> ((res_q & ~$past(bit_en)) == '0));
    a_r6_merge_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fill == FILL_KEEP_A) |=> (((res_q ^ $past(keep_val)) & ~$past(bit_en)) == '0));
    a_r1_enabled_bits: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> (((res_q ^ $past(lut_val)) & $past(bit_en)) == '0));

endmodule

// File: rtl/ternlog_unit.sv
module ternlog_unit
    import ternlog_pkg::*;
#(
    parameter int unsigned VEC_W = DEF_VEC_W,
    localparam int unsigned MASK_W = VEC_W / ELEM_LO_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_vld,
    input  logic [VEC_W-1:0]  opa,
    input  logic [VEC_W-1:0]  opb,
    input  logic [VEC_W-1:0]  opc,
    input  logic [TT_W-1:0]   tt_imm,
    input  logic              elem_wide,
    input  logic [MASK_W-1:0] elem_mask,
    input  logic              mask_on,
    input  logic              zero_fill,
    output logic              res_vld,
    output logic [VEC_W-1:0]  res
);

    logic [VEC_W-1:0] lut_val;
    logic [VEC_W-1:0] bit_en;
    elem_sel_e        esz;
    fill_sel_e        fill;

    assign esz  = elem_wide ? ESZ_QWORD : ESZ_DWORD;
    assign fill = zero_fill ? FILL_ZERO : FILL_KEEP_A;

    ternlog_truth_slice #(.VEC_W(VEC_W), .TT_W(TT_W)) u_slice (
        .in_a       (opa),
        .in_b       (opb),
        .in_c       (opc),
        .table_bits (tt_imm),
        .lut_out    (lut_val)
    );

    ternlog_lane_pred #(.VEC_W(VEC_W)) u_pred (
        .clk     (clk),
        .rst_n   (rst_n),
        .esz     (esz),
        .mask    (elem_mask),
        .mask_en (mask_on),
        .bit_en  (bit_en)
    );

    ternlog_out_stage #(.VEC_W(VEC_W)) u_out (
        .clk      (clk),
        .rst_n    (rst_n),
        .take     (op_vld),
        .lut_val  (lut_val),
        .keep_val (opa),
        .bit_en   (bit_en),
        .fill     (fill),
        .vld_q    (res_vld),
        .res_q    (res)
    );

endmodule

// File: tb/ternlog_unit_bench.sv
module ternlog_unit_bench;

    localparam int W  = 512;
    localparam int MW = 16;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          op_vld;
    logic [W-1:0]  opa, opb, opc;
    logic [7:0]    tt_imm;
    logic          elem_wide;
    logic [MW-1:0] elem_mask;
    logic          mask_on;
    logic          zero_fill;
    logic          res_vld;
    logic [W-1:0]  res;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    ternlog_unit u_ternlog_unit (
        .clk(clk), .rst_n(rst_n), .op_vld(op_vld),
        .opa(opa), .opb(opb), .opc(opc), .tt_imm(tt_imm),
        .elem_wide(elem_wide), .elem_mask(elem_mask),
        .mask_on(mask_on), .zero_fill(zero_fill),
        .res_vld(res_vld), .res(res)
    );

    function automatic logic [W-1:0] rand_vec();
        logic [W-1:0] v;
        for (int k = 0; k < W/32; k++) v[k*32 +: 32] = $urandom;
        return v;
    endfunction

    function automatic logic [W-1:0] model(input logic [W-1:0] a, input logic [W-1:0] b,
                                           input logic [W-1:0] c, input logic [7:0] t,
                                           input logic wide, input logic [MW-1:0] m,
                                           input logic on, input logic zf);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) begin
            logic f, en;
            f  = t[{a[i], b[i], c[i]}];
            en = !on || (wide ? m[i/64] : m[i/32]);
            r[i] = en ? f : (zf ? 1'b0 : a[i]);
        end
        return r;
    endfunction

    task automatic check_vec(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %h exp %h", req, act, exp);
        end
    endtask

    task automatic check_bit(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s got %b exp %b", req, act, exp);
        end
    endtask

    // Present one operation at a falling edge; result is registered at the
    // next rising edge and sampled at the falling edge after it.
    task automatic issue(input logic [W-1:0] a, input logic [W-1:0] b, input logic [W-1:0] c,
                         input logic [7:0] t, input logic wide, input logic [MW-1:0] m,
                         input logic on, input logic zf);
        opa = a; opb = b; opc = c; tt_imm = t;
        elem_wide = wide; elem_mask = m; mask_on = on; zero_fill = zf;
        op_vld = 1'b1;
        @(negedge clk);
        op_vld = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [W-1:0] a, b, c, r1, hold;
        void'($urandom(32'd20240611));
        rst_n = 1'b0; op_vld = 1'b0;
        opa = '0; opb = '0; opc = '0; tt_imm = '0;
        elem_wide = 1'b0; elem_mask = '0; mask_on = 1'b0; zero_fill = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_bit("R9 valid after reset", res_vld, 1'b0);
        check_vec("R9 result after reset", res, '0);

        a = rand_vec(); b = rand_vec(); c = rand_vec();

        // R10 named functions
        issue(a, b, c, 8'h96, 1'b0, '0, 1'b0, 1'b0);
        check_vec("R10 xor3", res, a ^ b ^ c);
        check_bit("R7 valid one cycle later", res_vld, 1'b1);
        issue(a, b, c, 8'hE8, 1'b1, '0, 1'b0, 1'b1);
        check_vec("R10 majority", res, (a & b) | (a & c) | (b & c));
        issue(a, b, c, 8'hCA, 1'b0, '0, 1'b0, 1'b0);
        check_vec("R10 select", res, (a & b) | (~a & c));
        check_vec("R1 select vs model", res, model(a, b, c, 8'hCA, 1'b0, '0, 1'b0, 1'b0));

        // R2 element size ignored without mask
        issue(a, b, c, 8'h5B, 1'b0, 16'h1234, 1'b0, 1'b1);
        r1 = res;
        issue(a, b, c, 8'h5B, 1'b1, 16'h1234, 1'b0, 1'b1);
        check_vec("R2 size ignored unmasked", res, r1);

        // R7/R8 idle: valid drops, result holds with inputs changed
        hold = res;
        opa = rand_vec(); tt_imm = 8'hFF; mask_on = 1'b1;
        @(negedge clk);
        check_bit("R7 valid low when idle", res_vld, 1'b0);
        check_vec("R8 hold when idle", res, hold);

        // R3 alternating single lanes in 32-bit mode
        issue(a, b, c, 8'hFF, 1'b0, 16'h5555, 1'b1, 1'b1);
        for (int k = 0; k < 16; k++)
            check_vec("R3 dword lane", {480'b0, res[k*32 +: 32]},
                      {480'b0, (k % 2 == 0) ? 32'hFFFF_FFFF : 32'h0});
        issue(a, b, c, 8'hFF, 1'b0, 16'hAAAA, 1'b1, 1'b0);
        check_vec("R3 R6 odd lanes merge", res, model(a, b, c, 8'hFF, 1'b0, 16'hAAAA, 1'b1, 1'b0));

        // R4 upper mask bits ignored in 64-bit mode
        issue(a, b, c, 8'h96, 1'b1, 16'hFF00, 1'b1, 1'b1);
        check_vec("R4 R5 upper bits ignored zero", res, '0);
        issue(a, b, c, 8'h96, 1'b1, 16'hFF00, 1'b1, 1'b0);
        check_vec("R4 R6 upper bits ignored merge", res, a);
        issue(a, b, c, 8'h96, 1'b1, 16'h0081, 1'b1, 1'b1);
        check_vec("R4 qword lanes", res,
                  {(a[511:448] ^ b[511:448] ^ c[511:448]), 384'b0, (a[63:0] ^ b[63:0] ^ c[63:0])});

        // R5/R6 random blends
        for (int n = 0; n < 300; n++) begin
            logic [7:0] t; logic wd, on, zf; logic [MW-1:0] m;
            a = rand_vec(); b = rand_vec(); c = rand_vec();
            t = 8'($urandom); m = MW'($urandom);
            wd = 1'($urandom); on = 1'($urandom); zf = 1'($urandom);
            issue(a, b, c, t, wd, m, on, zf);
            check_vec(zf ? "R5 R1 random" : "R6 R1 random", res, model(a, b, c, t, wd, m, on, zf));
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule